// File: doc/BRIEF.md
# Two-Wire Slave Start Detector and Clock Hold

This block is the slave-side clock control for an I2C-style two-wire bus. It samples the raw SDA and SCL lines through synchronizers and looks for a start condition, which is SDA falling while SCL is high. A detected start sets a start flag, and that flag can be routed to an interrupt request. When the master then pulls SCL low, the block holds SCL low as a wait state. This gives the host time to prepare for the address byte. The hold ends only when the host writes 1 to clear the start flag.

A second, independent option holds SCL low after the bit counter reports an overflow. When this option is enabled, the hold engages once SCL is low and lasts until the host clears the overflow flag. The SCL output is an open-drain pull-low enable. There is no protocol state machine, no glitch filter and no slew control. Only a slave uses this logic, because a master generates SCL itself.

Top module: `twi_clk_hold`

## Requirements
- R1: After reset, `start_flag`, `ovf_flag`, `start_irq` and `scl_pull_low` are all 0.
- R2: A falling `sda_in` while `scl_in` is high sets `start_flag`. The flag is visible after the third rising clock edge following the input change, and not after the second.
- R3: A falling `sda_in` while `scl_in` is low does not set `start_flag`, and neither does a rising `sda_in` at any level of `scl_in`.
- R4: `start_irq` is 1 exactly when `start_flag` is 1 and `start_irq_en` is 1, in the same cycle.
- R5: While `start_flag` is set, the first falling `scl_in` asserts `scl_pull_low` after the third rising clock edge following that fall. While SCL stays high after the start, `scl_pull_low` stays 0.
- R6: Once asserted by the start hold, `scl_pull_low` stays 1 even after the master releases SCL, for as long as `start_flag` is not cleared.
- R7: A 1 on `start_clr` for one cycle clears `start_flag` and releases the start hold at the next rising clock edge.
- R8: An `ovf_pulse` sets `ovf_flag` at the next rising edge, and a 1 on `ovf_clr` clears it at the next rising edge. For both flags, a set and a clear in the same cycle leave the flag set.
- R9: With `ovf_hold_en` = 1, a set `ovf_flag` asserts `scl_pull_low` one rising edge after synchronized SCL is seen low. If SCL is high, the hold waits until SCL goes low. The hold releases at the rising edge where `ovf_flag` is cleared.
- R10: With `ovf_hold_en` = 0, a counter overflow never asserts `scl_pull_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| ovf_pulse | input | 1 | One-cycle bit counter overflow |
| start_clr | input | 1 | Host write-1 clear of the start flag |
| ovf_clr | input | 1 | Host write-1 clear of the overflow flag |
| start_irq_en | input | 1 | Routes the start flag to `start_irq` |
| ovf_hold_en | input | 1 | Enables holding SCL low after overflow |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter overflow seen |
| start_irq | output | 1 | Start interrupt request |
| scl_pull_low | output | 1 | Open-drain pull-low enable for SCL |

## Verification
A change on a bus line reaches a flag or the pull-low output after three rising edges: two synchronizer stages, then the state register. Flag-clear writes and overflow pulses act at the next rising edge. An overflow hold follows its enabling condition by one more edge. The bench drives inputs just after a falling edge and counts whole cycles to the falling edge after the due rising edge before sampling. For the line latency it also checks one cycle early, which must still show the old value. The bus is modelled as open drain: the SCL line the block sees is the master's drive ANDed with the negated pull-low. This lets the stretch be observed on the line itself.

// File: rtl/twi_hold_pkg.sv
package twi_hold_pkg;
  localparam int unsigned LINE_SDA = 0;
  localparam int unsigned LINE_SCL = 1;
  localparam int unsigned LINES    = 2;

  typedef struct packed {
    logic flag;
    logic hold;
  } flag_hold_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned WIDTH     = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain       <= {STAGES{RESET_VAL}};
        prev_q[b]   <= RESET_VAL;
      end else begin
        chain       <= {chain[STAGES-2:0], raw[b]};
        prev_q[b]   <= chain[LAST];
      end
    end
    assign sync_q[b] = chain[LAST];
  end
endmodule

// File: rtl/twi_start_detect.sv
module twi_start_detect
  import twi_hold_pkg::*;
(
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] prev,
  output logic             start_pulse,
  output logic             scl_fall,
  output logic             scl_low
);
  always_comb begin
    start_pulse = prev[LINE_SDA] & ~cur[LINE_SDA] & cur[LINE_SCL] & prev[LINE_SCL];
    scl_fall    = prev[LINE_SCL] & ~cur[LINE_SCL];
    scl_low     = ~cur[LINE_SCL];
  end
endmodule

// File: rtl/twi_flag_hold.sv
module twi_flag_hold
  import twi_hold_pkg::*;
#(
  parameter string TAG = "flag"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_p,
  input  logic       clr_wr,
  input  logic       hold_en,
  input  logic       engage,
  output flag_hold_t st
);
  flag_hold_t st_nxt;

  always_comb begin
    st_nxt.flag = set_p | (st.flag & ~clr_wr);
    if (clr_wr)
      st_nxt.hold = 1'b0;
    else
      st_nxt.hold = st.hold | (st.flag & hold_en & engage);
  end

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= st_nxt;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    set_p |=> st.flag); // R8
  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !set_p) |=> (!st.flag && !st.hold)); // R7
  AST_HOLD_ENGAGE: assert property (@(posedge clk) disable iff (rst)
    $rose(st.hold) |-> $past(hold_en && engage)); // R5
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (st.hold && !clr_wr) |=> st.hold); // R6
endmodule

// File: rtl/twi_clk_hold.sv
module twi_clk_hold
  import twi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  input  logic ovf_pulse,
  input  logic start_clr,
  input  logic ovf_clr,
  input  logic start_irq_en,
  input  logic ovf_hold_en,
  output logic start_flag,
  output logic ovf_flag,
  output logic start_irq,
  output logic scl_pull_low
);
  logic [LINES-1:0] raw_lines, cur_lines, prev_lines;
  logic             start_pulse, scl_fall, scl_low;
  flag_hold_t       start_st, ovf_st;

  always_comb begin
    raw_lines           = '0;
    raw_lines[LINE_SDA] = sda_in;
    raw_lines[LINE_SCL] = scl_in;
  end

  twi_line_sync #(
    .STAGES(SYNC_STAGES), .WIDTH(LINES), .RESET_VAL(1'b1)
  ) u_sync (
    .clk(clk), .rst(rst), .raw(raw_lines), .sync_q(cur_lines), .prev_q(prev_lines)
  );

  twi_start_detect u_det (
    .cur(cur_lines), .prev(prev_lines),
    .start_pulse(start_pulse), .scl_fall(scl_fall), .scl_low(scl_low)
  );

  twi_flag_hold #(.TAG("start")) u_start (
    .clk(clk), .rst(rst), .set_p(start_pulse), .clr_wr(start_clr),
    .hold_en(1'b1), .engage(scl_fall), .st(start_st)
  );

  twi_flag_hold #(.TAG("ovf")) u_ovf (
    .clk(clk), .rst(rst), .set_p(ovf_pulse), .clr_wr(ovf_clr),
    .hold_en(ovf_hold_en), .engage(scl_low), .st(ovf_st)
  );

  assign start_flag   = start_st.flag;
  assign ovf_flag     = ovf_st.flag;
  assign start_irq    = start_st.flag & start_irq_en;
  assign scl_pull_low = start_st.hold | ovf_st.hold;

  AST_PULL_SOURCE: assert property (@(posedge clk) disable iff (rst)
    scl_pull_low |-> (start_flag || ovf_flag)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !start_flag |-> !start_irq); // R4
endmodule

// File: tb/tb_twi_clk_hold.sv
`timescale 1ns/1ps
module tb_twi_clk_hold;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_m = 1'b1, scl_m = 1'b1;
  logic ovf_pulse = 1'b0, start_clr = 1'b0, ovf_clr = 1'b0;
  logic start_irq_en = 1'b0, ovf_hold_en = 1'b0;
  logic start_flag, ovf_flag, start_irq, scl_pull_low;
  logic scl_line;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull_low;

  twi_clk_hold dut (
    .clk(clk), .rst(rst), .sda_in(sda_m), .scl_in(scl_line),
    .ovf_pulse(ovf_pulse), .start_clr(start_clr), .ovf_clr(ovf_clr),
    .start_irq_en(start_irq_en), .ovf_hold_en(ovf_hold_en),
    .start_flag(start_flag), .ovf_flag(ovf_flag),
    .start_irq(start_irq), .scl_pull_low(scl_pull_low)
  );

  function automatic logic exp_flag(input logic scl_high);
    return scl_high;
  endfunction

  function automatic logic exp_irq(input logic scl_high, input logic en);
    return scl_high & en;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulse_start_clr();
    start_clr = 1'b1; cyc(1); start_clr = 1'b0;
  endtask

  task automatic pulse_ovf_clr();
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 start_flag", start_flag, 1'b0);
    check("R1 ovf_flag", ovf_flag, 1'b0);
    check("R1 irq", start_irq, 1'b0);
    check("R1 pull", scl_pull_low, 1'b0);

    // start with SCL high, exact latency
    start_irq_en = 1'b1;
    cyc(2);
    sda_m = 1'b0;
    cyc(2);
    check("R2 early", start_flag, 1'b0);
    cyc(1);
    check("R2 set", start_flag, 1'b1);
    check("R4 irq on", start_irq, 1'b1);
    check("R5 no hold while scl high", scl_pull_low, 1'b0);

    // master drops SCL
    scl_m = 1'b0;
    cyc(2);
    check("R5 early", scl_pull_low, 1'b0);
    cyc(1);
    check("R5 hold", scl_pull_low, 1'b1);

    // master releases, line stays low
    scl_m = 1'b1;
    cyc(5);
    check("R6 pull kept", scl_pull_low, 1'b1);
    check("R6 line low", scl_line, 1'b0);

    pulse_start_clr();
    check("R7 flag clr", start_flag, 1'b0);
    check("R7 released", scl_pull_low, 1'b0);
    cyc(4);
    // stop condition: SDA rises while SCL high
    sda_m = 1'b1;
    cyc(4);
    check("R3 rising sda", start_flag, 1'b0);

    // irq disabled
    start_irq_en = 1'b0;
    sda_m = 1'b0;
    cyc(4);
    check("R4 flag", start_flag, 1'b1);
    check("R4 irq off", start_irq, 1'b0);
    pulse_start_clr();
    sda_m = 1'b1;
    cyc(4);

    // SDA falls while SCL low
    scl_m = 1'b0; cyc(4);
    sda_m = 1'b0; cyc(4);
    check("R3 sda fall scl low", start_flag, 1'b0);
    check("R3 no pull", scl_pull_low, 1'b0);
    sda_m = 1'b1; cyc(4);
    scl_m = 1'b1; cyc(4);

    // set wins over clear for start flag
    sda_m = 1'b0;
    cyc(2);
    start_clr = 1'b1;
    cyc(1);
    start_clr = 1'b0;
    check("R8 start set wins", start_flag, 1'b1);
    pulse_start_clr();
    sda_m = 1'b1;
    cyc(4);

    // overflow without hold
    scl_m = 1'b0; cyc(4);
    ovf_pulse = 1'b1; cyc(1); ovf_pulse = 1'b0;
    check("R8 ovf set", ovf_flag, 1'b1);
    cyc(3);
    check("R10 no ovf hold", scl_pull_low, 1'b0);
    pulse_ovf_clr();
    check("R8 ovf clr", ovf_flag, 1'b0);

    // overflow with hold, SCL low
    ovf_hold_en = 1'b1;
    ovf_pulse = 1'b1; cyc(1); ovf_pulse = 1'b0;
    check("R9 not yet", scl_pull_low, 1'b0);
    cyc(1);
    check("R9 hold", scl_pull_low, 1'b1);
    pulse_ovf_clr();
    check("R9 release", scl_pull_low, 1'b0);
    check("R9 flag clr", ovf_flag, 1'b0);

    // overflow with hold, SCL high first
    scl_m = 1'b1; cyc(4);
    ovf_pulse = 1'b1; cyc(1); ovf_pulse = 1'b0;
    cyc(3);
    check("R9 waits for low", scl_pull_low, 1'b0);
    scl_m = 1'b0;
    cyc(2);
    check("R9 low early", scl_pull_low, 1'b0);
    cyc(1);
    check("R9 low hold", scl_pull_low, 1'b1);
    pulse_ovf_clr();
    check("R9 release 2", scl_pull_low, 1'b0);

    // ovf set wins over clear
    ovf_hold_en = 1'b0;
    ovf_pulse = 1'b1; ovf_clr = 1'b1; cyc(1);
    ovf_pulse = 1'b0; ovf_clr = 1'b0;
    check("R8 ovf set wins", ovf_flag, 1'b1);
    pulse_ovf_clr();
    scl_m = 1'b1; cyc(4);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic hi, en;
      hi = 1'($urandom % 2);
      en = 1'($urandom % 2);
      start_irq_en = en;
      scl_m = hi; cyc(4);
      sda_m = 1'b0; cyc(4);
      check("R2 rnd flag", start_flag, exp_flag(hi));
      check("R4 rnd irq", start_irq, exp_irq(hi, en));
      if (hi) begin
        scl_m = 1'b0; cyc(4);
        check("R5 rnd hold", scl_pull_low, 1'b1);
      end
      pulse_start_clr();
      check("R7 rnd release", scl_pull_low, 1'b0);
      check("R7 rnd flag", start_flag, 1'b0);
      scl_m = 1'b0; cyc(4);
      sda_m = 1'b1; cyc(3);
      scl_m = 1'b1; cyc(4);
      check("R3 rnd idle", start_flag, 1'b0);
    end

    finish_run();
  end
endmodule